// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block produces the horizontal timing of a character-based video timing controller. On every character-clock enable it advances an 8-bit character-position counter. It also runs a 4-bit counter that measures how long the sync pulse has lasted. It drives the horizontal sync pulse and the horizontal display-enable window. It also gives a one-clock end-of-line strobe that the vertical logic uses to advance its own counters.

Four values are programmable: the line total, the displayed width, the sync start position and the sync width. They are loaded from a shared write-data bus by one strobe per value and can be changed at any moment. The counters are never shadowed, so a new value acts at once on the live comparisons. A parameter selects one of five controller variants. The variants behave differently when a programmed value is moved below a counter that is already running.

Top module: `line_timing_gen`

## Requirements
- R1: A synchronous reset sets the position counter to 0 and drives sync low. The programmable values return to their parameter defaults: total 63, displayed 40, sync position 46, sync width 14.
- R2: The position counter and the sync state change only on clocks where `ce_i` is high. Each enabled clock that does not end the line adds exactly one to the position, modulo 256.
- R3: On an enabled clock where the position equals the line total, `eol_o` is high for that clock and the position becomes 0 on the next clock.
- R4: `hde_o` is high exactly while the position is below the programmed displayed width.
- R5: On an enabled clock where the position equals the sync position, sync turns on for the next clock. It stays on for W enabled characters, where W is the width, and a width of 0 gives 16 characters on variants 0, 2, 3 and 4.
- R6: On variants 0, 1 and 2, if the total is moved below the running position, the counter continues up to 255, wraps to 0 and ends the line only when it next equals the total.
- R7: On variants 3 and 4, if the position is above the total, the next enabled clock ends the line: `eol_o` pulses and the position returns to 0.
- R8: If the width is moved below the elapsed sync length while sync is on, sync stays on. The sync counter wraps through 15 and sync ends when the counter reaches the new width.
- R9: On variant 1, a width of 0 drops sync in the same clock and ends it at the next enabled clock. A sync that starts while the width is 0 never shows at the output.
- R10: A write strobe loads `wdata_i` in the clock it is sampled, whether `ce_i` is high or not, and the new value drives the comparisons from the next clock. The width takes `wdata_i[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Character-clock enable |
| wdata_i | input | 8 | Write data shared by all programmable values |
| wr_total_i | input | 1 | Load line total |
| wr_disp_i | input | 1 | Load displayed width |
| wr_spos_i | input | 1 | Load sync position |
| wr_swid_i | input | 1 | Load sync width (low nibble) |
| hcount_o | output | 8 | Current character position |
| hsync_o | output | 1 | Horizontal sync |
| hde_o | output | 1 | Horizontal display enable |
| eol_o | output | 1 | End-of-line strobe |

## Verification
A write shows up in the outputs one clock after its strobe is sampled. A character-clock enable moves the position and sync state at the next edge. `eol_o` and `hde_o` are combinational outputs of the current state, so they are valid in the same clock. The bench keeps a model updated at every rising edge. A quarter period before the next edge it queues the expected outputs, and the monitor compares them against the three variant instances at that point. Each comparison therefore lands after all registers have settled and after the driver has changed its inputs.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [1:0] {
        OVF_WRAP = 2'd0,
        OVF_END  = 2'd1
    } ovf_mode_e;

    function automatic ovf_mode_e ovf_mode(input int variant);
        return (variant >= 3) ? OVF_END : OVF_WRAP;
    endfunction

    function automatic bit zero_cancels(input int variant);
        return variant == 1;
    endfunction

endpackage

// File: rtl/lt_regs.sv
module lt_regs #(
    parameter int CNT_W     = 8,
    parameter int SW_W      = 4,
    parameter int TOTAL_RST = 63,
    parameter int DISP_RST  = 40,
    parameter int SPOS_RST  = 46,
    parameter int SWID_RST  = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             wr_total_i,
    input  logic             wr_disp_i,
    input  logic             wr_spos_i,
    input  logic             wr_swid_i,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] disp_o,
    output logic [CNT_W-1:0] spos_o,
    output logic [SW_W-1:0]  swid_o
);

    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] disp;
        logic [CNT_W-1:0] spos;
        logic [SW_W-1:0]  swid;
    } regs_t;

    localparam regs_t RST_VAL = '{
        total: CNT_W'(TOTAL_RST),
        disp:  CNT_W'(DISP_RST),
        spos:  CNT_W'(SPOS_RST),
        swid:  SW_W'(SWID_RST)
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_total_i) r_d.total = wdata_i;
        if (wr_disp_i)  r_d.disp  = wdata_i;
        if (wr_spos_i)  r_d.spos  = wdata_i;
        if (wr_swid_i)  r_d.swid  = wdata_i[SW_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= RST_VAL;
        else       r_q <= r_d;
    end

    assign total_o = r_q.total;
    assign disp_o  = r_q.disp;
    assign spos_o  = r_q.spos;
    assign swid_o  = r_q.swid;

    assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_total_i |=> total_o == $past(wdata_i));

endmodule

// File: rtl/lt_char_counter.sv
module lt_char_counter #(
    parameter int CNT_W   = 8,
    parameter int VARIANT = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ce_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] hcc_o,
    output logic             line_end_o
);

    localparam bit END_EARLY = (lt_pkg::ovf_mode(VARIANT) == lt_pkg::OVF_END);

    typedef struct packed {
        logic [CNT_W-1:0] hcc;
    } cnt_t;

    cnt_t s_d, s_q;
    logic at_total;
    logic past_total;

    always_comb begin
        at_total   = (s_q.hcc == total_i);
        past_total = END_EARLY && (s_q.hcc > total_i);
        line_end_o = at_total || past_total;
        s_d = s_q;
        if (ce_i) begin
            s_d.hcc = line_end_o ? '0 : s_q.hcc + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign hcc_o = s_q.hcc;

    assert_hold_without_enable_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(hcc_o));

    assert_step_or_wrap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && hcc_o != total_i && !(END_EARLY && hcc_o > total_i))
        |=> hcc_o == $past(hcc_o) + CNT_W'(1));

    assert_restart_at_total_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && hcc_o == total_i) |=> hcc_o == '0);

    generate
        if (END_EARLY) begin : g_early
            assert_cut_short_R7: assert property (@(posedge clk_i) disable iff (rst_i)
                (ce_i && hcc_o > total_i) |=> hcc_o == '0);
        end
    endgenerate

endmodule

// File: rtl/lt_sync_counter.sv
module lt_sync_counter #(
    parameter int CNT_W   = 8,
    parameter int SW_W    = 4,
    parameter int VARIANT = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ce_i,
    input  logic [CNT_W-1:0] hcc_i,
    input  logic [CNT_W-1:0] spos_i,
    input  logic [SW_W-1:0]  swid_i,
    output logic             hsync_o
);

    localparam bit ZERO_CANCEL = lt_pkg::zero_cancels(VARIANT);

    typedef struct packed {
        logic            active;
        logic [SW_W-1:0] hsc;
    } sync_t;

    sync_t s_d, s_q;
    logic [SW_W-1:0] hsc_nxt;
    logic            at_start;
    logic            cancel;

    always_comb begin
        hsc_nxt  = s_q.hsc + SW_W'(1);
        at_start = (hcc_i == spos_i);
        cancel   = ZERO_CANCEL && (swid_i == '0);
        s_d = s_q;
        if (ce_i) begin
            if (at_start) begin
                s_d.active = 1'b1;
                s_d.hsc    = '0;
            end else if (s_q.active) begin
                if (cancel) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.hsc = hsc_nxt;
                    if (hsc_nxt == swid_i) s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign hsync_o = s_q.active && !cancel;

    assert_sync_start_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && hcc_i == spos_i) |=> (s_q.active && s_q.hsc == '0));

    assert_sync_frozen_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(s_q));

    assert_sync_overrun_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && s_q.active && hcc_i != spos_i && !cancel && hsc_nxt != swid_i)
        |=> s_q.active);

    generate
        if (ZERO_CANCEL) begin : g_cancel
            assert_zero_cancel_R9: assert property (@(posedge clk_i) disable iff (rst_i)
                (ce_i && s_q.active && swid_i == '0 && hcc_i != spos_i) |=> !s_q.active);
        end
    endgenerate

endmodule

// File: rtl/line_timing_gen.sv
module line_timing_gen #(
    parameter int CNT_W     = 8,
    parameter int SW_W      = 4,
    parameter int VARIANT   = 0,
    parameter int TOTAL_RST = 63,
    parameter int DISP_RST  = 40,
    parameter int SPOS_RST  = 46,
    parameter int SWID_RST  = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ce_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             wr_total_i,
    input  logic             wr_disp_i,
    input  logic             wr_spos_i,
    input  logic             wr_swid_i,
    output logic [CNT_W-1:0] hcount_o,
    output logic             hsync_o,
    output logic             hde_o,
    output logic             eol_o
);

    logic [CNT_W-1:0] total_w, disp_w, spos_w;
    logic [SW_W-1:0]  swid_w;
    logic             line_end_w;

    lt_regs #(
        .CNT_W(CNT_W), .SW_W(SW_W),
        .TOTAL_RST(TOTAL_RST), .DISP_RST(DISP_RST),
        .SPOS_RST(SPOS_RST), .SWID_RST(SWID_RST)
    ) u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .wdata_i(wdata_i),
        .wr_total_i(wr_total_i), .wr_disp_i(wr_disp_i),
        .wr_spos_i(wr_spos_i), .wr_swid_i(wr_swid_i),
        .total_o(total_w), .disp_o(disp_w), .spos_o(spos_w), .swid_o(swid_w)
    );

    lt_char_counter #(.CNT_W(CNT_W), .VARIANT(VARIANT)) u_char (
        .clk_i(clk_i), .rst_i(rst_i), .ce_i(ce_i), .total_i(total_w),
        .hcc_o(hcount_o), .line_end_o(line_end_w)
    );

    lt_sync_counter #(.CNT_W(CNT_W), .SW_W(SW_W), .VARIANT(VARIANT)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .ce_i(ce_i), .hcc_i(hcount_o),
        .spos_i(spos_w), .swid_i(swid_w), .hsync_o(hsync_o)
    );

    always_comb begin
        hde_o = (hcount_o < disp_w);
        eol_o = ce_i && line_end_w;
    end

    assert_eol_then_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        eol_o |=> hcount_o == '0);

    assert_eol_needs_enable_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        eol_o |-> ce_i);

endmodule

// File: tb/line_timing_gen_tb.sv
module line_timing_gen_tb;

    localparam int CLK_P = 10;
    localparam int NDUT  = 3;
    localparam int VARS [NDUT] = '{0, 1, 3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b1;
    logic [7:0] wdata = '0;
    logic       wr_total = 1'b0, wr_disp = 1'b0, wr_spos = 1'b0, wr_swid = 1'b0;

    logic [7:0] hc   [NDUT];
    logic       hs   [NDUT];
    logic       de   [NDUT];
    logic       eol  [NDUT];

    line_timing_gen #(.VARIANT(0)) u_dut (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .wdata_i(wdata),
        .wr_total_i(wr_total), .wr_disp_i(wr_disp), .wr_spos_i(wr_spos), .wr_swid_i(wr_swid),
        .hcount_o(hc[0]), .hsync_o(hs[0]), .hde_o(de[0]), .eol_o(eol[0]));

    line_timing_gen #(.VARIANT(1)) u_dut_v1 (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .wdata_i(wdata),
        .wr_total_i(wr_total), .wr_disp_i(wr_disp), .wr_spos_i(wr_spos), .wr_swid_i(wr_swid),
        .hcount_o(hc[1]), .hsync_o(hs[1]), .hde_o(de[1]), .eol_o(eol[1]));

    line_timing_gen #(.VARIANT(3)) u_dut_v3 (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .wdata_i(wdata),
        .wr_total_i(wr_total), .wr_disp_i(wr_disp), .wr_spos_i(wr_spos), .wr_swid_i(wr_swid),
        .hcount_o(hc[2]), .hsync_o(hs[2]), .hde_o(de[2]), .eol_o(eol[2]));

    initial forever #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int phase  = 1;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    int m_tot = 63, m_disp = 40, m_spos = 46, m_swid = 14;
    int m_hcc [NDUT];
    int m_hsc [NDUT];
    bit m_on  [NDUT];

    typedef struct {
        int       idx;
        int       req;
        logic [7:0] hcc;
        logic     hs;
        logic     de;
        logic     eol;
    } exp_t;

    exp_t sb [$];

    function automatic bit line_over(int i);
        return (m_hcc[i] == m_tot) || (VARS[i] >= 3 && m_hcc[i] > m_tot);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tot = 63; m_disp = 40; m_spos = 46; m_swid = 14;
            for (int i = 0; i < NDUT; i++) begin
                m_hcc[i] = 0; m_hsc[i] = 0; m_on[i] = 1'b0;
            end
            armed = 1'b1;
        end else begin
            if (ce) begin
                for (int i = 0; i < NDUT; i++) begin
                    bit start;
                    start = (m_hcc[i] == m_spos);
                    if (start) begin
                        m_on[i] = 1'b1; m_hsc[i] = 0;
                    end else if (m_on[i]) begin
                        if (VARS[i] == 1 && m_swid == 0) m_on[i] = 1'b0;
                        else begin
                            m_hsc[i] = (m_hsc[i] + 1) % 16;
                            if (m_hsc[i] == m_swid) m_on[i] = 1'b0;
                        end
                    end
                    m_hcc[i] = line_over(i) ? 0 : (m_hcc[i] + 1) % 256;
                end
            end
            if (wr_total) m_tot  = int'(wdata);
            if (wr_disp)  m_disp = int'(wdata);
            if (wr_spos)  m_spos = int'(wdata);
            if (wr_swid)  m_swid = int'(wdata[3:0]);
        end
    end

    // Driver side of the scoreboard: queue expectations before each edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (armed && !done) begin
            for (int i = 0; i < NDUT; i++) begin
                exp_t e;
                e.idx = i;
                e.req = phase;
                e.hcc = 8'(m_hcc[i]);
                e.hs  = m_on[i] && !(VARS[i] == 1 && m_swid == 0);
                e.de  = m_hcc[i] < m_disp;
                e.eol = ce && !rst && line_over(i);
                if (rst) e.eol = ce && line_over(i);
                sb.push_back(e);
            end
        end
    end

    // Monitor: pop and compare
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() != 0);
            e = sb.pop_front();
            checks++;
            if (hc[e.idx] !== e.hcc || hs[e.idx] !== e.hs ||
                de[e.idx] !== e.de || eol[e.idx] !== e.eol) begin
                errors++;
                $display("FAIL R%0d variant %0d at %0t: hcc/hs/de/eol actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
                         e.req, VARS[e.idx], $time, hc[e.idx], hs[e.idx], de[e.idx], eol[e.idx],
                         e.hcc, e.hs, e.de, e.eol);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        wdata = 8'(val);
        wr_total = (sel == 0); wr_disp = (sel == 1);
        wr_spos  = (sel == 2); wr_swid = (sel == 3);
        @(negedge clk);
        wr_total = 1'b0; wr_disp = 1'b0; wr_spos = 1'b0; wr_swid = 1'b0;
    endtask

    task automatic wait_pos(input int p);
        while (hc[0] !== 8'(p)) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        phase = 1;                         // R1 reset state
        run(3);
        rst = 1'b0;
        run(4);
        phase = 10;                        // R10 program a short line
        wr(0, 19); wr(1, 12); wr(2, 14); wr(3, 3);
        phase = 3;                         // R3, R4, R5 normal lines
        run(70);
        phase = 5;                         // R5 width zero
        wr(3, 0);
        run(60);
        wr(3, 3);
        phase = 2;                         // R2 sparse enables, R10 writes with enable low
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            ce = ($urandom % 3) != 0;
            if (k == 40) begin ce = 1'b0; wdata = 8'd9; wr_disp = 1'b1; end
            else wr_disp = 1'b0;
        end
        @(negedge clk); ce = 1'b1; wr_disp = 1'b0;
        phase = 6;                         // R6 and R7 total lowered below the count
        wr(0, 40);
        wait_pos(30);
        wr(0, 10);
        run(300);
        phase = 8;                         // R8 width lowered during sync
        wr(0, 40); wr(2, 5); wr(3, 10);
        run(50);
        wait_pos(10);
        wr(3, 2);
        run(80);
        phase = 9;                         // R9 variant 1 cancel by zero width
        wr(3, 6);
        run(45);
        wait_pos(8);
        wr(3, 0);
        run(10);
        wr(3, 6);
        run(50);
        phase = 1;                         // R1 reset in mid-line
        @(negedge clk); rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(20);
        done = 1'b1;
        #(CLK_P);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule